// File: doc/BRIEF.md
# Clause-22 Management Bus Master

This block runs one register access at a time to an Ethernet PHY over the two-wire management bus. A host pulses `start` for one cycle with a read/write select, a PHY address, a register address and, for writes, sixteen bits of data. The block latches them, raises `busy`, and shifts out a 64-bit-period frame on the data line while producing the management clock by dividing the system clock. A read hands the line to the PHY for the turnaround and data bits, and `read_data` shows the word collected from the PHY once `busy` drops.

The management clock runs only during a transaction. Each bit period lasts `CLK_DIV` system cycles: low for the first half and high for the second. Outgoing data changes only as a period begins, which is where the clock falls. Incoming data is sampled at the system edge on which the clock rises. Bit periods are numbered 0 to 63 in the order they are sent.

Top module: `mgmt_bus_master`

## Requirements
- R1: A `start` pulse while `busy` is low begins a transaction, and `busy` is high in the cycle after that pulse. `rw`, `phy_addr`, `reg_addr` and `write_data` are taken only in the pulse cycle and may change afterwards without effect.
- R2: Bit periods 0 to 31 carry logic 1 (preamble), period 32 carries 0 and period 33 carries 1.
- R3: Periods 34 and 35 carry the opcode. `rw`=0 selects a read and sends 1 then 0. `rw`=1 selects a write and sends 0 then 1.
- R4: Periods 36 to 40 carry `phy_addr` and periods 41 to 45 carry `reg_addr`, each sent MSB first.
- R5: During a read, `mdio_oe` is high in periods 0 to 45 and low in periods 46 to 63.
- R6: During a write, periods 46 and 47 carry 1 then 0, periods 48 to 63 carry `write_data` MSB first, and `mdio_oe` is high in all 64 periods.
- R7: During a read, `mdio_i` is sampled in periods 48 to 63, and the first sample becomes bit 15 of the result. `read_data` takes the complete word in the cycle `busy` falls and holds it until the next read completes. A write leaves `read_data` unchanged.
- R8: Each bit period lasts `CLK_DIV` system cycles, with `mdc` low for the first `CLK_DIV/2` and high for the rest. `mdio_o` does not change while `mdc` is high.
- R9: While `busy` is low, `mdc` and `mdio_oe` are both low.
- R10: A `start` pulse while `busy` is high is ignored. The running frame, its length and its result are unaffected.
- R11: `busy` stays high for exactly 64 × `CLK_DIV` system cycles per transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request strobe |
| rw | input | 1 | 0 = read, 1 = write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| write_data | input | 16 | Word to write |
| read_data | output | 16 | Word returned by the last read |
| busy | output | 1 | Transaction in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The bench builds the block with `CLK_DIV` = 6. This keeps a whole frame to 384 cycles, so many randomised reads and writes fit into a short run. The half period of three cycles also leaves a low phase in which the bench model can change its reply bit before the sampling edge. With a divider that small, the bench can also measure the exact length of every bit period and of every high phase, time a `start` pulse into the middle of a frame, and check each field of each frame.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

    localparam int ADDR_W      = 5;
    localparam int DATA_W      = 16;
    localparam int FRAME_BITS  = 64;
    localparam int IDX_W       = $clog2(FRAME_BITS);
    localparam int RELEASE_BIT = 46;   // first period the PHY owns the line on a read
    localparam int DATA_BIT    = 48;   // first data period

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic [DATA_W-1:0] wdata;
    } mgmt_req_t;

    // Bit FRAME_BITS-1 goes out first.
    function automatic logic [FRAME_BITS-1:0] mk_frame(mgmt_req_t r);
        logic [1:0]        op;
        logic [DATA_W+1:0] tail;
        op   = r.wr ? 2'b01 : 2'b10;
        tail = r.wr ? {2'b10, r.wdata} : {(DATA_W+2){1'b1}};
        return {{32{1'b1}}, 2'b01, op, r.phy, r.regad, tail};
    endfunction

endpackage

// File: rtl/mgmt_clk_div.sv
module mgmt_clk_div #(
    parameter int CLK_DIV = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic end_stb
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt == CW'(CLK_DIV - 1))
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign mdc      = run && (cnt >= CW'(HALF));
    assign rise_stb = run && (cnt == CW'(HALF - 1));
    assign end_stb  = run && (cnt == CW'(CLK_DIV - 1));
endmodule

// File: rtl/mgmt_frame_seq.sv
module mgmt_frame_seq
    import mgmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  mgmt_req_t  req,
    input  logic       rise_stb,
    input  logic       end_stb,
    output logic       busy,
    output logic       wr_lat,
    output logic       mdio_o,
    output logic       mdio_oe,
    output logic       capture_en,
    output logic       done_stb
);
    logic [FRAME_BITS-1:0] frame;
    logic [IDX_W-1:0]      bit_idx;
    logic                  last_bit;

    assign last_bit = (bit_idx == IDX_W'(FRAME_BITS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            wr_lat  <= 1'b0;
            frame   <= '1;
            bit_idx <= '0;
        end else if (start && !busy) begin
            busy    <= 1'b1;
            wr_lat  <= req.wr;
            frame   <= mk_frame(req);
            bit_idx <= '0;
        end else if (busy && end_stb) begin
            frame <= {frame[FRAME_BITS-2:0], 1'b1};
            if (last_bit)
                busy <= 1'b0;
            else
                bit_idx <= bit_idx + 1'b1;
        end
    end

    assign mdio_o     = frame[FRAME_BITS-1];
    assign mdio_oe    = busy && (wr_lat || (bit_idx < IDX_W'(RELEASE_BIT)));
    assign capture_en = busy && !wr_lat && rise_stb && (bit_idx >= IDX_W'(DATA_BIT));
    assign done_stb   = busy && end_stb && last_bit;
endmodule

// File: rtl/mgmt_rd_capture.sv
module mgmt_rd_capture
    import mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture_en,
    input  logic              sample,
    input  logic              done_stb,
    input  logic              is_read,
    output logic [DATA_W-1:0] read_data
);
    logic [DATA_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            read_data <= '0;
        end else begin
            if (capture_en)
                shreg <= {shreg[DATA_W-2:0], sample};
            if (done_stb && is_read)
                read_data <= shreg;
        end
    end
endmodule

// File: rtl/mgmt_bus_master.sv
module mgmt_bus_master
    import mgmt_pkg::*;
#(
    parameter int CLK_DIV = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              rw,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] write_data,
    output logic [DATA_W-1:0] read_data,
    output logic              busy,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    mgmt_req_t req;
    logic      rise_stb, end_stb, capture_en, done_stb, wr_lat;

    assign req = '{wr: rw, phy: phy_addr, regad: reg_addr, wdata: write_data};

    mgmt_clk_div #(.CLK_DIV(CLK_DIV)) u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .end_stb  (end_stb)
    );

    mgmt_frame_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .req        (req),
        .rise_stb   (rise_stb),
        .end_stb    (end_stb),
        .busy       (busy),
        .wr_lat     (wr_lat),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .capture_en (capture_en),
        .done_stb   (done_stb)
    );

    mgmt_rd_capture u_cap (
        .clk        (clk),
        .rst        (rst),
        .capture_en (capture_en),
        .sample     (mdio_i),
        .done_stb   (done_stb),
        .is_read    (!wr_lat),
        .read_data  (read_data)
    );
endmodule

// File: rtl/mgmt_bus_master_chk.sv
module mgmt_bus_master_chk
    import mgmt_pkg::*;
#(
    parameter int CLK_DIV = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              wr_lat,
    input logic              mdc,
    input logic              mdio_o,
    input logic              mdio_oe,
    input logic [DATA_W-1:0] read_data
);
    localparam int FRAME_CYC = FRAME_BITS * CLK_DIV;

    int unsigned busy_cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy)
            busy_cnt <= 0;
        else
            busy_cnt <= busy_cnt + 1;
    end

    assert_busy_from_start_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    assert_write_drives_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_lat) |-> mdio_oe);

    assert_result_held_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(read_data));

    assert_hold_while_high_R8: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> $stable(mdio_o));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !mdio_oe));

    assert_no_restart_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && start && busy_cnt < FRAME_CYC - 1) |=> busy);

    assert_frame_length_R11: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(busy)) |-> ($past(busy_cnt) == FRAME_CYC - 1));
endmodule

bind mgmt_bus_master mgmt_bus_master_chk #(.CLK_DIV(CLK_DIV)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .wr_lat    (wr_lat),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .read_data (read_data)
);

// File: tb/mgmt_bus_master_test.sv
`timescale 1ns/1ps
module mgmt_bus_master_test;
    localparam int DIV  = 6;
    localparam int HALF = DIV / 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        rw = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] write_data = '0;
    logic [15:0] read_data;
    logic        busy, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    mgmt_bus_master #(.CLK_DIV(DIV)) uut (
        .clk(clk), .rst(rst), .start(start), .rw(rw),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .write_data(write_data),
        .read_data(read_data), .busy(busy), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // ---------------- bus monitor / PHY model ----------------
    logic [15:0] phy_reply = '0;
    logic [63:0] obits, oebits;
    int  k, busy_cyc, since_rise, hi_len, rises;
    bit  prev_mdc, prev_busy, bad_timing, bad_hold;

    always @(negedge clk) begin
        if (busy) begin
            busy_cyc   = busy_cyc + 1;
            since_rise = since_rise + 1;
            if (mdc) hi_len = hi_len + 1;
            if (mdc && !prev_mdc) begin
                if (k < 64) begin
                    obits[k]  = mdio_o;
                    oebits[k] = mdio_oe;
                end
                if (rises > 0 && since_rise != DIV) bad_timing = 1;
                since_rise = 0;
                rises = rises + 1;
            end
            if (mdc && prev_mdc && k < 64 && mdio_o != obits[k]) bad_hold = 1;
            if (!mdc && prev_mdc) begin
                if (hi_len != DIV - HALF) bad_timing = 1;
                hi_len = 0;
                k = k + 1;
            end
            mdio_i = (k >= 48 && k < 64) ? phy_reply[63 - k] : 1'b1;
        end else if (!prev_busy) begin
            k = 0; busy_cyc = 0; since_rise = 0; hi_len = 0; rises = 0;
            bad_timing = 0; bad_hold = 0; obits = '0; oebits = '0;
            mdio_i = 1'b1;
        end
        prev_mdc  = mdc;
        prev_busy = busy;
    end

    // ---------------- expectations ----------------
    function automatic logic [63:0] exp_bits(bit wr, logic [4:0] pa, logic [4:0] ra, logic [15:0] wd);
        logic [63:0] e;
        for (int i = 0; i < 32; i++) e[i] = 1'b1;
        e[32] = 1'b0; e[33] = 1'b1;
        e[34] = !wr;  e[35] = wr;
        for (int i = 0; i < 5; i++) begin
            e[36 + i] = pa[4 - i];
            e[41 + i] = ra[4 - i];
        end
        e[46] = 1'b1; e[47] = 1'b0;
        for (int i = 0; i < 16; i++) e[48 + i] = wr ? wd[15 - i] : 1'b1;
        return e;
    endfunction

    function automatic logic [63:0] exp_oe(bit wr);
        logic [63:0] e;
        for (int i = 0; i < 64; i++) e[i] = wr || (i < 46);
        return e;
    endfunction

    function automatic logic [63:0] span(int lo, int hi);
        logic [63:0] m = '0;
        for (int i = lo; i <= hi; i++) m[i] = 1'b1;
        return m;
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    logic [15:0] last_read = '0;

    task automatic run_txn(bit wr, logic [4:0] pa, logic [4:0] ra, logic [15:0] wd,
                           logic [15:0] reply, bit inject);
        logic [63:0] e, eo, m;
        @(negedge clk);
        phy_reply = reply;
        rw = wr; phy_addr = pa; reg_addr = ra; write_data = wd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
        chk(busy === 1'b1, "R1 busy after start", 64'(busy), 64'd1);
        // R1: inputs scrambled after the pulse cycle
        rw = $urandom; phy_addr = $urandom; reg_addr = $urandom; write_data = $urandom;
        if (inject) begin
            repeat (50 + ($urandom % 100)) @(negedge clk);
            rw = !wr; phy_addr = ~pa; reg_addr = ~ra; write_data = ~wd; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        #1;
        e  = exp_bits(wr, pa, ra, wd);
        eo = exp_oe(wr);
        chk(busy_cyc == 64 * DIV, "R11 busy length", 64'(busy_cyc), 64'(64 * DIV));
        chk(!bad_timing && !bad_hold && rises == 64, "R8 period, phase and hold",
            {bad_timing, bad_hold, 62'(rises)}, 64'd64);
        m = span(0, 33);
        chk(((obits ^ e) & m) == 0, "R2 preamble and start", obits & m, e & m);
        m = span(34, 35);
        chk(((obits ^ e) & m) == 0, "R3 opcode", obits & m, e & m);
        m = span(36, 45);
        chk(((obits ^ e) & m) == 0, "R4 addresses", obits & m, e & m);
        if (wr) begin
            m = span(46, 63);
            chk(((obits ^ e) & m) == 0, "R6 turnaround and data", obits & m, e & m);
            chk(oebits == eo, "R6 enable held", oebits, eo);
            chk(read_data == last_read, "R7 write leaves result", 64'(read_data), 64'(last_read));
        end else begin
            chk(oebits == eo, "R5 enable release", oebits, eo);
            chk(read_data == reply, "R7 read result", 64'(read_data), 64'(reply));
            last_read = reply;
        end
        if (inject)
            chk(obits[45:0] == e[45:0], "R10 start ignored while busy", obits, e);
        chk(!mdc && !mdio_oe, "R9 idle lines", {mdc, mdio_oe}, 64'd0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(busy == 0, "R9 reset busy", 64'(busy), 0);
        chk(!mdc && !mdio_oe, "R9 reset lines", {mdc, mdio_oe}, 0);
        chk(read_data == 0, "R7 reset result", 64'(read_data), 0);
        // directed corners
        run_txn(1'b1, 5'd31, 5'd0,  16'hFFFF, 16'h0000, 0);
        run_txn(1'b1, 5'd0,  5'd31, 16'h0000, 16'hFFFF, 0);
        run_txn(1'b0, 5'd1,  5'd16, 16'h1234, 16'hFFFF, 0);
        run_txn(1'b0, 5'd30, 5'd1,  16'h0000, 16'h0000, 0);
        run_txn(1'b1, 5'd10, 5'd21, 16'h8001, 16'h5A5A, 0);
        run_txn(1'b0, 5'd21, 5'd10, 16'hFFFF, 16'hA5A5, 1);
        run_txn(1'b1, 5'd5,  5'd9,  16'h7FFE, 16'h1111, 1);
        // constrained random
        for (int n = 0; n < 16; n++)
            run_txn(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom),
                    16'($urandom), (n % 4) == 3);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule